// File: doc/BRIEF.md
# Effects DSP program sequencer with single-step debug

This block drives the instruction address of an effects DSP. In normal operation it waits for a sample-period tick, then issues a 512-instruction program one instruction per clock (addresses 0 through 511), then idles until the next tick. A 32-bit debug register, written and read by a host, lets software stop free-running execution. In single-step mode, each step request runs exactly one instruction at an address the host chooses, after which the sequencer halts again.

The sequencer also watches two inputs from the ALU. A saturation indication is captured into a sticky flag together with the address of the instruction that saturated. The condition code of the most recently executed instruction is mirrored into the debug register. The block owns the delay-memory base address counter, which counts down once per sample period. The host can zero it through a strobe bit of the debug register. Instruction decode, the ALU and the memories are outside this block; the sequencer only provides the address and an issue qualifier.

Top module: `dsp_seq_dbg`

## Requirements
- R1: After reset `exec_en` is 0, `pc` is 0, `dbac` is 0 and `dbg_rdata` reads 0.
- R2: In free-run mode, a `tick` seen while idle starts a pass. From the next cycle, `exec_en` is high for exactly 512 consecutive cycles with `pc` counting 0..511. It then stays low until the next tick. A tick that arrives during a pass does not disturb the pass.
- R3: A write with bit 15 = 1 enters single-step mode. `exec_en` is 0 from the cycle after the write and stays 0 through later ticks. Bit 15 reads back as the last value written.
- R4: A write with bit 15 = 1 and bit 14 = 1 makes `exec_en` high for exactly the one cycle after the write, with `pc` equal to write bits 8:0. Bits 8:0 read back the last written address.
- R5: A write with bit 15 = 0 while in single-step mode returns the sequencer to idle free-run. The next tick starts a pass at address 0.
- R6: An issued instruction with `sat_in` high, while bit 25 is clear, sets bit 25 and loads bits 24:16 with that instruction's `pc`.
- R7: While bit 25 is set, further saturation events leave bits 24:16 unchanged. A write with bit 25 = 1 does not clear the flag.
- R8: A write with bit 25 = 0 clears the flag. It takes priority over a saturation event in the same cycle.
- R9: Bits 13:9 show the `cc_in` value of the most recently issued instruction and hold while nothing is issued.
- R10: `dbac` decrements by one on every `tick` and wraps from 0 to all ones.
- R11: A write with bit 31 = 1 zeroes `dbac` in the next cycle, taking priority over a same-cycle tick.
- R12: Bits 31, 30:26 and 14 always read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | Sample-period pulse |
| dbg_we | input | 1 | Host write strobe for the debug register |
| dbg_wdata | input | 32 | Host write data |
| dbg_rdata | output | 32 | Debug register read value |
| sat_in | input | 1 | ALU saturation indication for the issued instruction |
| cc_in | input | 5 | ALU condition code for the issued instruction |
| exec_en | output | 1 | An instruction is issued this cycle |
| pc | output | 9 | Address of the issued instruction |
| dbac | output | DBAC_W | Delay-memory base address counter |

## Verification
A wrong sequencing state shows at `exec_en` and `pc` within one cycle. Examples are a missed wrap to idle, a step that issues twice, or a halt that still follows ticks. The bench checks `exec_en` and `pc` every cycle of a full pass and for every step address. A corrupted saturation or condition-code capture shows in the debug readback on the cycle after the issuing cycle. The counter is compared against an arithmetic model after every tick and zeroing strobe, so a lost or doubled decrement is visible on the next comparison.

// File: rtl/dsp_seq_pkg.sv
package dsp_seq_pkg;
  // Host-visible register layout; positions are decoded by software.
  localparam int ADDR_W    = 9;
  localparam int CC_W      = 5;
  localparam int PROG_LAST = (1 << ADDR_W) - 1;

  localparam int B_ZERO    = 31;
  localparam int B_SATF    = 25;
  localparam int SATA_LO   = 16;
  localparam int B_MODE    = 15;
  localparam int B_GO      = 14;
  localparam int CC_LO     = 9;

  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_RUN  = 2'd1,
    ST_STEP = 2'd2,
    ST_HALT = 2'd3
  } seq_state_e;
endpackage

// File: rtl/seq_pc_ctrl.sv
module seq_pc_ctrl
  import dsp_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic              mode_i,
  input  logic              go_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              exec_o,
  output logic [ADDR_W-1:0] pc_o
);
  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic              in_dbg;
  logic              mode_take;

  assign in_dbg    = (state_q == ST_STEP) || (state_q == ST_HALT);
  assign mode_take = wr_i && (mode_i || in_dbg);

  always_comb begin
    state_d = state_q;
    pc_d    = pc_q;
    if (mode_take) begin
      if (!mode_i) begin
        state_d = ST_WAIT;
        pc_d    = '0;
      end else if (go_i) begin
        state_d = ST_STEP;
        pc_d    = addr_i;
      end else begin
        state_d = ST_HALT;
      end
    end else begin
      unique case (state_q)
        ST_WAIT: begin
          if (tick_i) begin
            state_d = ST_RUN;
            pc_d    = '0;
          end
        end
        ST_RUN: begin
          if (pc_q == ADDR_W'(PROG_LAST)) begin
            state_d = ST_WAIT;
            pc_d    = '0;
          end else begin
            pc_d = pc_q + 1'b1;
          end
        end
        ST_STEP: state_d = ST_HALT;
        ST_HALT: state_d = ST_HALT;
        default: state_d = ST_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_WAIT;
      pc_q    <= '0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
    end
  end

  assign exec_o = (state_q == ST_RUN) || (state_q == ST_STEP);
  assign pc_o   = pc_q;

  assert_pass_ends_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_RUN && pc_q == ADDR_W'(PROG_LAST) && !(wr_i && mode_i))
      |=> (state_q == ST_WAIT));

  assert_pass_counts_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_RUN && pc_q != ADDR_W'(PROG_LAST) && !(wr_i && mode_i))
      |=> (pc_q == $past(pc_q) + 1'b1) && exec_o);

  assert_step_once_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_STEP && !(wr_i && mode_i && go_i)) |=> !exec_o);

  assert_halt_deaf_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_HALT && !wr_i) |=> (state_q == ST_HALT));
endmodule

// File: rtl/seq_status_cap.sv
module seq_status_cap
  import dsp_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              exec_i,
  input  logic              sat_i,
  input  logic [CC_W-1:0]   cc_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              clr_i,
  output logic              flag_o,
  output logic [ADDR_W-1:0] sat_addr_o,
  output logic [CC_W-1:0]   cc_o
);
  logic              flag_q, flag_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CC_W-1:0]   cc_q, cc_d;
  logic              hit;
  logic              addr_en;

  assign hit     = exec_i && sat_i;
  assign addr_en = hit && !flag_q && !clr_i;

  always_comb begin
    flag_d = flag_q;
    if (clr_i)      flag_d = 1'b0;
    else if (hit)   flag_d = 1'b1;
    addr_d = addr_en ? pc_i : addr_q;
    cc_d   = exec_i  ? cc_i : cc_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      addr_q <= '0;
      cc_q   <= '0;
    end else begin
      flag_q <= flag_d;
      addr_q <= addr_d;
      cc_q   <= cc_d;
    end
  end

  assign flag_o     = flag_q;
  assign sat_addr_o = addr_q;
  assign cc_o       = cc_q;

  assert_sat_sticky_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> flag_q && $stable(addr_q));

  assert_sat_clear_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    clr_i |=> !flag_q);

  assert_sat_take_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (hit && !flag_q && !clr_i) |=> flag_q && (addr_q == $past(pc_i)));

  assert_cc_hold_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    !exec_i |=> $stable(cc_q));
endmodule

// File: rtl/seq_dbac.sv
module seq_dbac #(
  parameter int DBAC_W = 20
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              zero_i,
  output logic [DBAC_W-1:0] cnt_o
);
  logic [DBAC_W-1:0] cnt_q, cnt_d;
  logic              cnt_en;

  assign cnt_en = tick_i || zero_i;

  always_comb begin
    cnt_d = cnt_q;
    if (zero_i)      cnt_d = '0;
    else if (tick_i) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  assert_dbac_zero_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    zero_i |=> (cnt_q == '0));

  assert_dbac_down_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    (tick_i && !zero_i) |=> (cnt_q == $past(cnt_q) - 1'b1));

  assert_dbac_idle_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    (!tick_i && !zero_i) |=> $stable(cnt_q));
endmodule

// File: rtl/dsp_seq_dbg.sv
module dsp_seq_dbg
  import dsp_seq_pkg::*;
#(
  parameter int DBAC_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              dbg_we,
  input  logic [31:0]       dbg_wdata,
  output logic [31:0]       dbg_rdata,
  input  logic              sat_in,
  input  logic [CC_W-1:0]   cc_in,
  output logic              exec_en,
  output logic [ADDR_W-1:0] pc,
  output logic [DBAC_W-1:0] dbac
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  // host-held fields
  logic              mode_q, mode_d;
  logic [ADDR_W-1:0] saddr_q, saddr_d;

  always_comb begin
    mode_d  = dbg_we ? dbg_wdata[B_MODE]      : mode_q;
    saddr_d = dbg_we ? dbg_wdata[ADDR_W-1:0]  : saddr_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= 1'b0;
      saddr_q <= '0;
    end else if (dbg_we) begin
      mode_q  <= mode_d;
      saddr_q <= saddr_d;
    end
  end

  logic              sat_flag;
  logic [ADDR_W-1:0] sat_addr;
  logic [CC_W-1:0]   cc_q;
  logic              sat_clr;
  logic              zero_req;

  assign sat_clr  = dbg_we && !dbg_wdata[B_SATF];
  assign zero_req = dbg_we &&  dbg_wdata[B_ZERO];

  seq_pc_ctrl u_pc (
    .clk    (clk),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .wr_i   (dbg_we),
    .mode_i (dbg_wdata[B_MODE]),
    .go_i   (dbg_wdata[B_GO]),
    .addr_i (dbg_wdata[ADDR_W-1:0]),
    .exec_o (exec_en),
    .pc_o   (pc)
  );

  seq_status_cap u_stat (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .exec_i     (exec_en),
    .sat_i      (sat_in),
    .cc_i       (cc_in),
    .pc_i       (pc),
    .clr_i      (sat_clr),
    .flag_o     (sat_flag),
    .sat_addr_o (sat_addr),
    .cc_o       (cc_q)
  );

  seq_dbac #(.DBAC_W(DBAC_W)) u_dbac (
    .clk    (clk),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .zero_i (zero_req),
    .cnt_o  (dbac)
  );

  // strobes and unused positions read as zero
  assign dbg_rdata = {1'b0, 5'b00000, sat_flag, sat_addr, mode_q, 1'b0, cc_q, saddr_q};

  assert_step_needs_go_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode_q && exec_en) |-> $past(dbg_we && dbg_wdata[B_MODE] && dbg_wdata[B_GO]));

  assert_step_quiet_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (dbg_we && dbg_wdata[B_MODE] && !dbg_wdata[B_GO]) |=> !exec_en);
endmodule

// File: tb/dsp_seq_dbg_tb.sv
module dsp_seq_dbg_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW         = 20;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          tick;
  logic          dbg_we;
  logic [31:0]   dbg_wdata;
  logic [31:0]   dbg_rdata;
  logic          sat_in;
  logic [4:0]    cc_in;
  logic          exec_en;
  logic [8:0]    pc;
  logic [DW-1:0] dbac;

  int total = 0;
  int bad   = 0;
  logic [DW-1:0] exp_dbac;

  always #(CLK_PERIOD/2) clk = ~clk;

  dsp_seq_dbg #(.DBAC_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .dbg_we(dbg_we),
    .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata), .sat_in(sat_in),
    .cc_in(cc_in), .exec_en(exec_en), .pc(pc), .dbac(dbac)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    dbg_we = 1'b1; dbg_wdata = d;
    @(negedge clk);
    dbg_we = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick = 1'b1;
    exp_dbac = exp_dbac - 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        bad++; total++;
        $display("FAIL watchdog act=%0d exp=done", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; tick = 1'b0; dbg_we = 1'b0; dbg_wdata = '0;
    sat_in = 1'b0; cc_in = '0; exp_dbac = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(exec_en == 1'b0, "R1 exec", 32'(exec_en), 0);
    chk(pc == 9'd0, "R1 pc", 32'(pc), 0);
    chk(dbac == '0, "R1 dbac", 32'(dbac), 0);
    chk(dbg_rdata == 32'd0, "R1 rdata", dbg_rdata, 0);

    // R2 full pass, with a stray tick mid-pass; R10 wrap from zero
    pulse_tick();
    chk(dbac == exp_dbac, "R10 wrap", 32'(dbac), 32'(exp_dbac));
    for (int i = 0; i < 512; i++) begin
      chk(exec_en && pc == 9'(i), "R2 pass", {22'd0, exec_en, pc}, {22'd0, 1'b1, 9'(i)});
      if (i == 100) begin tick = 1'b1; exp_dbac = exp_dbac - 1'b1; end
      if (i == 101) tick = 1'b0;
      @(negedge clk);
    end
    for (int k = 0; k < 4; k++) begin
      chk(!exec_en, "R2 idle", 32'(exec_en), 0);
      @(negedge clk);
    end
    chk(dbac == exp_dbac, "R10 count", 32'(dbac), 32'(exp_dbac));

    // R3 stop a running pass
    pulse_tick();
    repeat (10) @(negedge clk);
    wr(32'h0000_8000);
    chk(!exec_en, "R3 stop", 32'(exec_en), 0);
    pulse_tick();
    repeat (3) @(negedge clk);
    chk(!exec_en, "R3 tick ignored", 32'(exec_en), 0);
    chk(dbg_rdata[15], "R3 mode bit", 32'(dbg_rdata[15]), 1);

    // R4 / R9 every step address
    for (int a = 0; a < 512; a++) begin
      logic [4:0] cexp;
      cexp = 5'(a) ^ 5'h15;
      wr(32'h0000_C000 | 32'(a));
      cc_in = cexp;
      chk(exec_en && pc == 9'(a), "R4 step issue", {22'd0, exec_en, pc}, {22'd0, 1'b1, 9'(a)});
      @(negedge clk);
      cc_in = ~cexp;
      chk(!exec_en, "R4 single", 32'(exec_en), 0);
      chk(dbg_rdata[13:9] == cexp, "R9 cc", 32'(dbg_rdata[13:9]), 32'(cexp));
      chk(dbg_rdata[8:0] == 9'(a), "R4 addr rb", 32'(dbg_rdata[8:0]), a);
      chk(dbg_rdata[31] == 1'b0 && dbg_rdata[14] == 1'b0 && dbg_rdata[30:26] == 5'd0,
          "R12 zero bits", dbg_rdata, {16'd0, dbg_rdata[15], 1'b0, dbg_rdata[13:0]});
    end
    repeat (3) @(negedge clk);
    chk(dbg_rdata[13:9] == (5'h1f ^ 5'h15), "R9 hold", 32'(dbg_rdata[13:9]), 32'(5'h1f ^ 5'h15));

    // R6 / R7 / R8 saturation in step mode
    wr(32'h0000_C055);
    sat_in = 1'b1;
    @(negedge clk); sat_in = 1'b0;
    chk(dbg_rdata[25] && dbg_rdata[24:16] == 9'h055, "R6 capture",
        {22'd0, dbg_rdata[25:16]}, 32'h255);
    wr(32'h0200_C1AA);
    sat_in = 1'b1;
    @(negedge clk); sat_in = 1'b0;
    chk(dbg_rdata[25] && dbg_rdata[24:16] == 9'h055, "R7 sticky",
        {22'd0, dbg_rdata[25:16]}, 32'h255);
    wr(32'h0200_8000);
    chk(dbg_rdata[25], "R7 write one", 32'(dbg_rdata[25]), 1);
    wr(32'h0000_8000);
    chk(!dbg_rdata[25], "R8 clear", 32'(dbg_rdata[25]), 0);
    wr(32'h0000_C033);
    sat_in = 1'b1;
    @(negedge clk); sat_in = 1'b0;
    chk(dbg_rdata[25] && dbg_rdata[24:16] == 9'h033, "R6 recapture",
        {22'd0, dbg_rdata[25:16]}, 32'h233);

    // R5 leave step mode, keep flag
    wr(32'h0200_0000);
    chk(!exec_en && !dbg_rdata[15], "R5 idle", {30'd0, exec_en, dbg_rdata[15]}, 0);
    @(negedge clk);
    chk(!exec_en, "R5 waits", 32'(exec_en), 0);
    pulse_tick();
    chk(exec_en && pc == 9'd0, "R5 restart", {22'd0, exec_en, pc}, 32'h200);
    repeat (20) @(negedge clk);
    // R8 clear wins over same-cycle saturation (pc = 20 issuing)
    dbg_we = 1'b1; dbg_wdata = 32'h0; sat_in = 1'b1;
    @(negedge clk);
    dbg_we = 1'b0; sat_in = 1'b0;
    chk(!dbg_rdata[25], "R8 priority", 32'(dbg_rdata[25]), 0);
    chk(pc == 9'd21, "R2 run on", 32'(pc), 21);
    sat_in = 1'b1;
    @(negedge clk); sat_in = 1'b0;
    chk(dbg_rdata[25] && dbg_rdata[24:16] == 9'd21, "R6 run capture",
        {22'd0, dbg_rdata[25:16]}, 32'h215);
    repeat (600) @(negedge clk);
    chk(!exec_en, "R2 pass over", 32'(exec_en), 0);

    // R11 zero strobe beats tick
    dbg_we = 1'b1; dbg_wdata = 32'h8200_0000; tick = 1'b1;
    @(negedge clk);
    dbg_we = 1'b0; tick = 1'b0; exp_dbac = '0;
    chk(dbac == '0, "R11 zero", 32'(dbac), 0);
    chk(!dbg_rdata[31], "R12 strobe rb", 32'(dbg_rdata[31]), 0);
    pulse_tick();
    chk(dbac == exp_dbac, "R10 after zero", 32'(dbac), 32'(exp_dbac));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule